// File: doc/BRIEF.md
# General-Purpose I/O Bank Register Decoder

This block is the register front end of a 32-pin general-purpose I/O bank. A simple single-cycle register bus (address, read strobe, write strobe, byte enables, write data, registered read data) reaches a data register, a direction register and a pad sample register. It also reaches the configuration, mask and status registers of a separate interrupt sensing block. Each pin whose direction bit is set is driven from the matching data bit. Every clock, the sample register captures the already synchronised pad inputs.

Reads of the data offset merge two sources per bit: the driven value for output pins and the sampled pad value for input pins. Reads of the sample offset hide the bits of output pins. The interrupt trigger configuration, the any-edge select and the interrupt mask are held here and exported to the sensing block. Interrupt status is read from that block. Writing the status offset sends it a one-cycle clear pulse.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, pad_out, pad_oe, trig_cfg, edge_any, irq_mask, irq_clear and bus_rdata are all 0, and every stored register holds 0.
- R2: The direction register sits at offset 0x04 and the data register at 0x00. After the write edge, pad_oe equals the direction register and pad_out equals data AND direction. A read of 0x04 returns the direction register.
- R3: A read of offset 0x00 returns, per bit, the data bit where the direction bit is 1 and the sampled pad bit where it is 0.
- R4: On every clock the sample register captures pad_in, so it lags pad_in by one cycle. A read of offset 0x08 returns the sample register AND NOT direction, so output pins read 0.
- R5: The sample register at 0x08 is read-only. A write to 0x08 changes no register and no output.
- R6: bus_rdata is registered. It is valid in the cycle after the edge at which bus_rd is sampled high, and it is 0 after an edge at which bus_rd is low. If a read and a write happen in the same cycle, the read returns the value from before the write.
- R7: Only full-word accesses are accepted, meaning bus_be = 4'b1111 and address bits [1:0] = 0. Any other write is ignored, and any other read returns 0.
- R8: A write to an offset at or above 0x20 is ignored, and a read of such an offset returns 0.
- R9: Offsets 0x0C and 0x10 hold the trigger configuration for pins 0-15 and 16-31. They are exported as trig_cfg = {word@0x10, word@0x0C}, with pin n at bits 2n+1:2n. Offset 0x1C holds the any-edge select, exported as edge_any. All three read back.
- R10: Offset 0x14 holds the interrupt mask. It reads back and is exported as irq_mask.
- R11: A read of offset 0x18 returns irq_status as sampled at the read edge. A full write to 0x18 drives irq_clear with the write data for exactly the next cycle. Otherwise irq_clear is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Synchronised pad input levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables |
| trig_cfg | output | 64 | Two-bit trigger code per pin, to the interrupt sensing block |
| edge_any | output | 32 | Any-edge select per pin, to the interrupt sensing block |
| irq_mask | output | 32 | Interrupt mask, to the interrupt sensing block |
| irq_status | input | 32 | Interrupt status from the interrupt sensing block |
| irq_clear | output | 32 | One-cycle clear pulse to the interrupt sensing block |

## Verification
The hardest case to reach is a single access that stacks several conditions. One example is a data or sample read while some pins are outputs, their pad levels disagree with the data bits, and pad_in changed on the previous clock. Another is a read and a write to the same offset in the same cycle. Directed sequences set up these cases: a mixed direction mask, opposing pad and data patterns, and simultaneous read and write. A long randomised phase follows. It toggles pad_in every cycle, mixes partial byte enables, misaligned and undefined addresses into the traffic, and compares every output against a behavioural model on every clock.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic [63:0]       trig_cfg,
  output logic [31:0]       edge_any,
  output logic [31:0]       irq_mask,
  input  logic [31:0]       irq_status,
  output logic [31:0]       irq_clear
);

  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_SAMP = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_TLO  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_THI  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_EDGE = ADDR_W'(8'h1C);

  logic [31:0] data_q, dir_q, samp_q, tlo_q, thi_q, mask_q, edge_q;
  logic [31:0] rd_val;

  wire full_acc = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  wire wr_ok    = bus_wr && full_acc;
  wire rd_ok    = bus_rd && full_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      tlo_q  <= '0;
      thi_q  <= '0;
      mask_q <= '0;
      edge_q <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_DATA: data_q <= bus_wdata;
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_TLO:  tlo_q  <= bus_wdata;
        OFS_THI:  thi_q  <= bus_wdata;
        OFS_MASK: mask_q <= bus_wdata;
        OFS_EDGE: edge_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= pad_in;
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_val = (data_q & dir_q) | (samp_q & ~dir_q);
      OFS_DIR:  rd_val = dir_q;
      OFS_SAMP: rd_val = samp_q & ~dir_q;
      OFS_TLO:  rd_val = tlo_q;
      OFS_THI:  rd_val = thi_q;
      OFS_MASK: rd_val = mask_q;
      OFS_STAT: rd_val = irq_status;
      OFS_EDGE: rd_val = edge_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_clear <= '0;
    end else begin
      bus_rdata <= rd_ok ? rd_val : '0;
      irq_clear <= (wr_ok && bus_addr == OFS_STAT) ? bus_wdata : '0;
    end
  end

  assign pad_oe   = dir_q;
  assign pad_out  = data_q & dir_q;
  assign trig_cfg = {thi_q, tlo_q};
  assign edge_any = edge_q;
  assign irq_mask = mask_q;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == OFS_DIR) |=> pad_oe == $past(bus_wdata));

  p_samp_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> samp_q == $past(pad_in));

  p_samp_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SAMP) |=> $stable(pad_out) && $stable(pad_oe) && $stable(irq_mask));

  p_rdata_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  p_partial_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !full_acc) |=> $stable(pad_out) && $stable(pad_oe) && $stable(trig_cfg)
                              && $stable(edge_any) && $stable(irq_mask) && irq_clear == '0);

  p_clear_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> irq_clear == '0);

endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  localparam int AW = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 0, bus_wr = 0;
  logic [3:0]    bus_be = 4'hF;
  logic [31:0]   bus_wdata = '0, pad_in = '0, irq_status = '0;
  logic [31:0]   bus_rdata, pad_out, pad_oe, edge_any, irq_mask, irq_clear;
  logic [63:0]   trig_cfg;

  gpio_bank #(.ADDR_W(AW)) u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .trig_cfg(trig_cfg), .edge_any(edge_any),
    .irq_mask(irq_mask), .irq_status(irq_status), .irq_clear(irq_clear));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_data = 0, m_dir = 0, m_samp = 0, m_tlo = 0, m_thi = 0, m_mask = 0, m_edge = 0;
  logic [31:0] e_rdata = 0, e_clear = 0;
  string       rd_tag = "R1";
  bit          in_reset = 1;

  function automatic logic [31:0] ref_read(input logic [AW-1:0] a);
    case (int'(a))
      'h00: return (m_data & m_dir) | (m_samp & ~m_dir);
      'h04: return m_dir;
      'h08: return m_samp & ~m_dir;
      'h0C: return m_tlo;
      'h10: return m_thi;
      'h14: return m_mask;
      'h18: return irq_status;
      'h1C: return m_edge;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (int'(a))
      'h00: return "R3";
      'h04: return "R2";
      'h08: return "R4/R5";
      'h0C, 'h10, 'h1C: return "R9";
      'h14: return "R10";
      'h18: return "R11";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_samp = 0; m_tlo = 0; m_thi = 0; m_mask = 0; m_edge = 0;
      e_rdata = 0; e_clear = 0; rd_tag = "R1"; in_reset = 1;
    end else begin
      bit ok;
      ok = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
      in_reset = 0;
      if (!bus_rd) begin e_rdata = 0; rd_tag = "R6"; end
      else if (!ok) begin e_rdata = 0; rd_tag = "R7"; end
      else begin
        e_rdata = ref_read(bus_addr);
        rd_tag = bus_wr ? "R6" : tag_of(bus_addr);
      end
      e_clear = 0;
      if (bus_wr && ok) begin
        case (int'(bus_addr))
          'h00: m_data = bus_wdata;
          'h04: m_dir  = bus_wdata;
          'h0C: m_tlo  = bus_wdata;
          'h10: m_thi  = bus_wdata;
          'h14: m_mask = bus_wdata;
          'h18: e_clear = bus_wdata;
          'h1C: m_edge = bus_wdata;
          default: ;
        endcase
      end
      m_samp = pad_in;
    end
  end

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    string t;
    t = in_reset ? "R1" : "R2";
    cmp(t, "pad_oe", {32'h0, pad_oe}, {32'h0, m_dir});
    cmp(t, "pad_out", {32'h0, pad_out}, {32'h0, m_data & m_dir});
    cmp(in_reset ? "R1" : "R9", "trig_cfg", trig_cfg, {m_thi, m_tlo});
    cmp(in_reset ? "R1" : "R9", "edge_any", {32'h0, edge_any}, {32'h0, m_edge});
    cmp(in_reset ? "R1" : "R10", "irq_mask", {32'h0, irq_mask}, {32'h0, m_mask});
    cmp(in_reset ? "R1" : "R11", "irq_clear", {32'h0, irq_clear}, {32'h0, e_clear});
    cmp(rd_tag, "bus_rdata", {32'h0, bus_rdata}, {32'h0, e_rdata});
  end

  task automatic acc(input bit rd, input bit wr, input int a, input logic [31:0] d,
                     input logic [3:0] be = 4'hF);
    @(negedge clk);
    #0.1;
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d; bus_be = be;
  endtask

  initial begin
    // R1: reset held for a few cycles with busy inputs
    pad_in = 32'hFFFF_FFFF; irq_status = 32'h1234_5678;
    acc(1, 1, 'h04, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    #0.2 rst_n = 1;
    // R2 / R3: mixed direction, opposing pad and data patterns
    pad_in = 32'hF0F0_F0F0;
    acc(0, 1, 'h00, 32'hAAAA_AAAA);
    acc(0, 1, 'h04, 32'hFFFF_0000);
    acc(1, 0, 'h00, 0);
    acc(1, 0, 'h04, 0);
    acc(1, 0, 'h08, 0);                 // R4
    acc(0, 1, 'h08, 32'h5555_5555);     // R5 write to read-only sample
    acc(1, 0, 'h08, 0);
    acc(1, 0, 'h00, 0);
    // R6: simultaneous read and write of same offset
    acc(1, 1, 'h00, 32'h0F0F_0F0F);
    acc(1, 0, 'h00, 0);
    // R7: partial and misaligned
    acc(0, 1, 'h04, 32'h0, 4'b0111);
    acc(1, 0, 'h04, 0, 4'b1110);
    acc(0, 1, 'h06, 32'h0);
    acc(1, 0, 'h05, 0);
    acc(1, 0, 'h04, 0);
    // R8: undefined offsets
    acc(0, 1, 'h20, 32'hDEAD_BEEF);
    acc(1, 0, 'h3C, 0);
    // R9 / R10 / R11
    acc(0, 1, 'h0C, 32'h1111_2222);
    acc(0, 1, 'h10, 32'h3333_4444);
    acc(0, 1, 'h1C, 32'h8000_0001);
    acc(0, 1, 'h14, 32'h00FF_00FF);
    acc(1, 0, 'h0C, 0);
    acc(1, 0, 'h10, 0);
    acc(1, 0, 'h1C, 0);
    acc(1, 0, 'h14, 0);
    irq_status = 32'hCAFE_0001;
    acc(1, 0, 'h18, 0);
    acc(0, 1, 'h18, 32'h0000_00F1);
    acc(0, 0, 0, 0);
    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      int a;
      logic [3:0] be;
      a = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 63) : 4 * $urandom_range(0, 8);
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      pad_in = $urandom;
      irq_status = $urandom;
      acc($urandom_range(0, 1), $urandom_range(0, 2) == 0, a, $urandom, be);
    end
    acc(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule